// File: doc/BRIEF.md
# Bus Cycle Timer

This block keeps the free-running time base of a serial bus node as one 32-bit word built from three chained counters. The lowest field counts sub-cycle ticks, the middle field counts bus cycles of 125 µs, and the top field counts seconds. A periodic tick enable, derived elsewhere from a 24.576 MHz reference, advances the sub-cycle field. Each field that reaches its last value returns to zero and moves the next field up by one.

A host port reads the complete word at any time and can overwrite it. A write loads all three fields in one clock. The block also gives a one-clock cycle-start pulse whenever a new bus cycle begins through counting. Only a hard reset clears the timer. A bus reset event is accepted as an input but leaves the timer alone.

Top module: `bus_cycle_timer`

## Requirements
- R1: While `rst_n` is low and in the first clock after it rises, `host_rdata` is 0000_0000h and `cyc_start` is 0.
- R2: Each clock with `tick_en` high and `host_wr` low raises the offset field (`host_rdata[11:0]`) by one. A clock with `tick_en` low leaves the whole word unchanged.
- R3: A tick while the offset is 3071 sets the offset to 0 and raises the cycle field (`host_rdata[24:12]`) by one in the same update.
- R4: When the offset wraps while the cycle field is 7999, the cycle field becomes 0 and the seconds field (`host_rdata[31:25]`) rises by one in the same update.
- R5: The seconds field wraps from 127 to 0, so a tick at 127/7999/3071 gives an all-zero word.
- R6: A host write loads the word in one clock. Seconds come from `host_wdata[31:25]`, cycle from `host_wdata[24:12]` and offset from `host_wdata[11:0]`.
- R7: A host write in the same clock as a tick loads the written word unchanged, and the tick is discarded.
- R8: `cyc_start` is high for exactly the one clock in which the offset has just wrapped to 0 through a tick. Loading an offset of 0 by a write does not raise it.
- R9: `bus_rst_evt` has no effect on the word or on `cyc_start`.
- R10: A written offset of 3072 or more, or a written cycle of 8000 or more, goes to 0 with a carry on that field's next increment.
- R11: `host_rdata` shows all three fields from the same clock, so a read right after a carry through all fields never mixes old and new fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| tick_en | input | 1 | Sub-cycle tick enable, about one every 40 ns |
| bus_rst_evt | input | 1 | Bus reset event, ignored by the timer |
| host_wr | input | 1 | Host write strobe for the timer word |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Current timer word |
| cyc_start | output | 1 | One-clock pulse at each counted cycle boundary |

## Verification
The carry chain is driven by short tick bursts from preloaded words. A preload just below each boundary separates a plain offset step from a cycle carry, a seconds carry and a full wrap to zero. A long run of 6144 ticks from zero checks that the cycle-start pulse appears only at real wraps and lines up with the offset counting. Writes with a tick in the same clock, writes of zero and out-of-range values, and bus reset pulses with and without a tick show write priority and show that a wrap comes only from counting and never from a load.

// File: rtl/ct_pkg.sv
package ct_pkg;
  // Default field layout of the timer word, low field first
  localparam int unsigned CT_OFS_W   = 12;
  localparam int unsigned CT_OFS_MOD = 3072;
  localparam int unsigned CT_CYC_W   = 13;
  localparam int unsigned CT_CYC_MOD = 8000;
  localparam int unsigned CT_SEC_W   = 7;
  localparam int unsigned CT_SEC_MOD = 128;
endpackage

// File: rtl/ct_wrap_counter.sv
module ct_wrap_counter #(
  parameter int unsigned W   = 12,
  parameter int unsigned MOD = 3072
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] q_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAX_V = W'(MOD - 1);

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         at_top;

  // Anything at or above the last legal value wraps on the next step
  assign at_top = (q_q >= MAX_V);
  assign wrap_o = inc_i && at_top && !load_i;

  always_comb begin
    q_d = q_q;
    if (load_i) begin
      q_d = load_val_i;
    end else if (inc_i) begin
      q_d = at_top ? '0 : q_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (load_i || inc_i) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  // R2: one step per increment below the top value
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && (q_q < MAX_V)) |=> (q_q == $past(q_q) + W'(1)));

  // R2: no increment and no load keeps the value
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(q_q));

  // R3 / R10: an increment at or above the top returns to zero
  a_r10_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && (q_q >= MAX_V)) |=> (q_q == '0));

  // R6 / R7: a load wins over an increment
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (q_q == $past(load_val_i)));
endmodule

// File: rtl/ct_cycle_strobe.sv
module ct_cycle_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  output logic strobe_o
);
  logic strobe_q;
  logic strobe_d;

  assign strobe_d = wrap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
    end
  end

  assign strobe_o = strobe_q;

  // R8: the pulse lasts one clock
  a_r8_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import ct_pkg::*;
#(
  parameter int unsigned OFS_W   = CT_OFS_W,
  parameter int unsigned OFS_MOD = CT_OFS_MOD,
  parameter int unsigned CYC_W   = CT_CYC_W,
  parameter int unsigned CYC_MOD = CT_CYC_MOD,
  parameter int unsigned SEC_W   = CT_SEC_W,
  parameter int unsigned SEC_MOD = CT_SEC_MOD,
  localparam int unsigned WORD_W = SEC_W + CYC_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_rst_evt,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              cyc_start
);
  localparam int unsigned OFS_LO = 0;
  localparam int unsigned CYC_LO = OFS_W;
  localparam int unsigned SEC_LO = OFS_W + CYC_W;

  logic [OFS_W-1:0] ofs_q;
  logic [CYC_W-1:0] cyc_q;
  logic [SEC_W-1:0] sec_q;
  logic             ofs_inc;
  logic             ofs_wrap;
  logic             cyc_wrap;
  logic             sec_wrap;
  logic             unused_inputs;

  // A bus reset event is deliberately not wired to any state
  assign unused_inputs = bus_rst_evt ^ sec_wrap;

  // Host write has priority; a tick in the same clock is dropped
  assign ofs_inc = tick_en && !host_wr;

  ct_wrap_counter #(.W(OFS_W), .MOD(OFS_MOD)) i_ofs (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (ofs_inc),
    .load_i    (host_wr),
    .load_val_i(host_wdata[OFS_LO +: OFS_W]),
    .q_o       (ofs_q),
    .wrap_o    (ofs_wrap)
  );

  ct_wrap_counter #(.W(CYC_W), .MOD(CYC_MOD)) i_cyc (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (ofs_wrap),
    .load_i    (host_wr),
    .load_val_i(host_wdata[CYC_LO +: CYC_W]),
    .q_o       (cyc_q),
    .wrap_o    (cyc_wrap)
  );

  ct_wrap_counter #(.W(SEC_W), .MOD(SEC_MOD)) i_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc_i     (cyc_wrap),
    .load_i    (host_wr),
    .load_val_i(host_wdata[SEC_LO +: SEC_W]),
    .q_o       (sec_q),
    .wrap_o    (sec_wrap)
  );

  ct_cycle_strobe i_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap_i  (ofs_wrap),
    .strobe_o(cyc_start)
  );

  // R11: the word is formed from registers updated on the same edge
  assign host_rdata = {sec_q, cyc_q, ofs_q};

  // R8: the pulse always coincides with a zero offset
  a_r8_strobe_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> (ofs_q == '0));

  // R4: seconds move only on a write or on a carry out of the cycle field
  a_r4_sec_only_on_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !cyc_wrap) |=> $stable(sec_q));

  // R6: a write shows up whole on the next clock
  a_r6_write_whole: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (host_rdata == $past(host_wdata)));

  // R2: with no tick and no write the word holds, whatever the bus reset does
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !host_wr) |=> $stable(host_rdata));
endmodule

// File: tb/test_bus_cycle_timer.sv
module test_bus_cycle_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_rst_evt;
  logic        host_wr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        cyc_start;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bus_cycle_timer i_bus_cycle_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .bus_rst_evt(bus_rst_evt),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cyc_start  (cyc_start)
  );

  function automatic logic [31:0] word(input int s, input int c, input int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic w, input logic [31:0] d, input logic b);
    @(negedge clk);
    tick_en     = t;
    host_wr     = w;
    host_wdata  = d;
    bus_rst_evt = b;
    @(posedge clk);
    #1;
    tick_en     = 1'b0;
    host_wr     = 1'b0;
    bus_rst_evt = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 word in reset", host_rdata, 32'h0);
    check("R1 strobe in reset", {31'h0, cyc_start}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 word after reset", host_rdata, 32'h0);
    check("R1 strobe after reset", {31'h0, cyc_start}, 32'h0);
  endtask

  task automatic t_count;
    step(1'b0, 1'b1, word(0, 0, 0), 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 32'h0, 1'b0);
    check("R2 five ticks", host_rdata, word(0, 0, 5));
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 32'h0, 1'b0);
    check("R2 hold without tick", host_rdata, word(0, 0, 5));
  endtask

  task automatic t_ofs_wrap;
    step(1'b0, 1'b1, word(3, 10, 3070), 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    check("R2 step to top", host_rdata, word(3, 10, 3071));
    check("R8 no strobe before wrap", {31'h0, cyc_start}, 32'h0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    check("R3 offset wrap carries", host_rdata, word(3, 11, 0));
    check("R8 strobe on wrap", {31'h0, cyc_start}, 32'h1);
    step(1'b0, 1'b0, 32'h0, 1'b0);
    check("R8 strobe one clock", {31'h0, cyc_start}, 32'h0);
  endtask

  task automatic t_cyc_wrap;
    step(1'b0, 1'b1, word(5, 7999, 3071), 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    check("R4 R11 cycle wrap carries to seconds", host_rdata, word(6, 0, 0));
  endtask

  task automatic t_sec_wrap;
    step(1'b0, 1'b1, word(127, 7999, 3071), 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    check("R5 full wrap to zero", host_rdata, 32'h0);
    check("R8 strobe on full wrap", {31'h0, cyc_start}, 32'h1);
  endtask

  task automatic t_write;
    step(1'b0, 1'b1, 32'hA5F0_3C96, 1'b0);
    check("R6 write pattern A", host_rdata, 32'hA5F0_3C96);
    step(1'b0, 1'b1, word(100, 4321, 1234), 1'b0);
    check("R6 write fields", host_rdata, word(100, 4321, 1234));
    step(1'b1, 1'b1, word(9, 20, 3071), 1'b0);
    check("R7 write beats tick", host_rdata, word(9, 20, 3071));
    check("R7 no strobe on write at top", {31'h0, cyc_start}, 32'h0);
    step(1'b0, 1'b1, word(9, 21, 0), 1'b0);
    check("R8 write of zero offset gives no strobe", {31'h0, cyc_start}, 32'h0);
  endtask

  task automatic t_bus_reset;
    step(1'b0, 1'b1, word(44, 555, 666), 1'b0);
    step(1'b0, 1'b0, 32'h0, 1'b1);
    check("R9 bus reset no tick", host_rdata, word(44, 555, 666));
    step(1'b1, 1'b0, 32'h0, 1'b1);
    check("R9 bus reset with tick", host_rdata, word(44, 555, 667));
    check("R9 no strobe from bus reset", {31'h0, cyc_start}, 32'h0);
  endtask

  task automatic t_out_of_range;
    step(1'b0, 1'b1, word(1, 3, 4000), 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    check("R10 offset above range wraps", host_rdata, word(1, 4, 0));
    step(1'b0, 1'b1, word(2, 8100, 3071), 1'b0);
    step(1'b1, 1'b0, 32'h0, 1'b0);
    check("R10 cycle above range wraps", host_rdata, word(3, 0, 0));
  endtask

  task automatic t_long_run;
    int strobes = 0;
    step(1'b0, 1'b1, word(0, 0, 0), 1'b0);
    for (int i = 0; i < 6144; i++) begin
      step(1'b1, 1'b0, 32'h0, 1'b0);
      if (cyc_start) strobes++;
    end
    check("R3 two cycles counted", host_rdata, word(0, 2, 0));
    check("R8 two strobes in two cycles", 32'(strobes), 32'd2);
  endtask

  initial begin
    rst_n       = 1'b0;
    tick_en     = 1'b0;
    bus_rst_evt = 1'b0;
    host_wr     = 1'b0;
    host_wdata  = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_count();
    t_ofs_wrap();
    t_cyc_wrap();
    t_sec_wrap();
    t_write();
    t_bus_reset();
    t_out_of_range();
    t_long_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule